// File: doc/BRIEF.md
# SPI Memory Card Initialisation Sequencer

This block is the host-side controller that takes a memory card working in SPI mode from power-up to a usable state. It starts when `initStart` is pulsed. First it asks the byte engine for a run of idle clocks with chip select held high, so the card can switch into SPI mode. It then sends the software reset command (CMD0). It can optionally read the operating-condition register with CMD58 and check that register's voltage window against the voltages the host supports. Finally it polls the card with CMD1 until the card reports that it has left the idle state.

The block does not shift any bits itself. It drives a byte-level command/response engine through a one-cycle start strobe together with command index, argument, CRC byte and a long-response flag. It consumes the engine's completion pulse, which comes with the R1 byte and, for CMD58, four OCR bytes assembled MSB first into 32 bits. The outcome is a held status code: ready, voltage failure, poll timeout, R1 error or bad reset response. The status remains until the next start.

Top module: `spi_card_init`

## Requirements
- R1: A start (`initStart` high while not busy) produces a one-cycle `dummyReq` pulse. `csHigh` stays 1 from that pulse until `dummyDone` is accepted, and no command is started in that window.
- R2: The first command after the idle clocks is CMD0 (index 0), with argument 0 and CRC byte 0x95.
- R3: The reset response must be exactly 0x01. A reply with any of bits 7..1 set ends with status 4 (R1 error). Any other reply ends with status 5 (bad reset).
- R4: With `checkOcr`=1, CMD58 (index 58, `cmdLongRsp`=1) follows CMD0. If OCR bits 23..15 have no set bit in common with `hostVolt[8:0]` (hostVolt bit i matching OCR bit 15+i), the run ends with status 2 (voltage fail) and no CMD1 is sent.
- R5: With `checkOcr`=0, CMD1 directly follows CMD0 and no CMD58 is sent.
- R6: CMD1 is sent with argument 0 and `cmdLongRsp`=0. It is re-sent each time the response is 0x01 (idle bit, bit 0, set).
- R7: A CMD1 response of 0x00 ends the run with status 1 (ready) and `ready`=1.
- R8: Exactly MAX_POLLS CMD1 commands are sent at most. If the last one still reports idle, the status is 3 (timeout). If the card leaves idle on the last attempt, the run still ends ready.
- R9: A CMD1 or CMD58 response with any of bits 7..1 set ends the run with status 4.
- R10: Only indices 0, 1 and 58 are ever issued. `cmdStart` lasts one cycle, and no new command starts before the previous one's `cmdDone`.
- R11: After the run ends, `seqDone` and `seqStatus` hold unchanged, with no commands, until the next `initStart`. An `initStart` while busy is ignored.
- R12: After reset, `seqDone`, `ready`, `cmdStart`, `dummyReq` and `csHigh` are 0 and `seqStatus` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| initStart | input | 1 | begin (or restart) the sequence |
| checkOcr | input | 1 | 1: read and check the OCR before polling |
| hostVolt | input | 9 | host-supported voltage window, matched to OCR[23:15] |
| dummyReq | output | 1 | request idle clocks from the byte engine |
| csHigh | output | 1 | force chip select inactive during idle clocks |
| dummyDone | input | 1 | idle clocks finished |
| cmdStart | output | 1 | one-cycle command start strobe |
| cmdIdx | output | 6 | command index |
| cmdArg | output | 32 | command argument |
| cmdCrc | output | 8 | CRC7 byte with end bit |
| cmdLongRsp | output | 1 | expect R1 plus four OCR bytes |
| cmdDone | input | 1 | response received pulse |
| rspR1 | input | 8 | R1 response byte |
| rspOcr | input | 32 | OCR bytes, first byte in bits 31..24 |
| seqDone | output | 1 | sequence finished, status valid |
| seqStatus | output | 3 | 0 none, 1 ready, 2 voltage fail, 3 timeout, 4 R1 error, 5 bad reset |
| ready | output | 1 | finished with status ready |

## Verification
A start seen at a clock edge raises `dummyReq` in the next cycle. Every command strobe appears one cycle after the completion that caused it. The final status and `seqDone` appear one cycle after the last accepted `cmdDone`. The engine model drives its pulses at the falling edge and reads the strobes at the falling edge, so each response is seen by the block at the following rising edge. The bench waits for `seqDone` before comparing status, command counts and order. It then waits further cycles to show that the results stay put.

// File: rtl/cardinit_pkg.sv
package cardinit_pkg;
  typedef enum logic [2:0] {
    ST_NONE   = 3'd0,
    ST_READY  = 3'd1,
    ST_VFAIL  = 3'd2,
    ST_TMO    = 3'd3,
    ST_R1ERR  = 3'd4,
    ST_BADRST = 3'd5
  } seqStatus_e;

  typedef struct packed {
    logic       clrAll;
    logic       incPoll;
    logic       setStatus;
    seqStatus_e code;
  } dpCtl_t;

  localparam logic [5:0] IDX_RESET = 6'd0;
  localparam logic [5:0] IDX_OPCND = 6'd1;
  localparam logic [5:0] IDX_RDOCR = 6'd58;
  localparam logic [7:0] CRC_RESET = 8'h95;
  localparam logic [7:0] CRC_OPCND = 8'hF9;
  localparam logic [7:0] CRC_RDOCR = 8'hFD;
endpackage

// File: rtl/cardinit_dp.sv
module cardinit_dp
  import cardinit_pkg::*;
#(
  parameter int MAX_POLLS = 16,
  parameter int VW = 9,
  parameter int VLO = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [7:0]    rspR1,
  input  logic [31:0]   rspOcr,
  input  logic [VW-1:0] hostVolt,
  output logic          r1Err,
  output logic          r1Idle,
  output logic          r1ExactIdle,
  output logic          voltOk,
  output logic          pollLast,
  output seqStatus_e    status
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] pollCnt;

  assign r1Err       = |rspR1[7:1];
  assign r1Idle      = rspR1[0];
  assign r1ExactIdle = (rspR1 == 8'h01);
  assign voltOk      = |(rspOcr[VLO +: VW] & hostVolt);
  assign pollLast    = (pollCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt <= '0;
      status  <= ST_NONE;
    end else begin
      if (ctl.clrAll) begin
        pollCnt <= '0;
        status  <= ST_NONE;
      end else begin
        if (ctl.incPoll)   pollCnt <= pollCnt + 1'b1;
        if (ctl.setStatus) status  <= ctl.code;
      end
    end
  end
endmodule

// File: rtl/cardinit_ctrl.sv
module cardinit_ctrl
  import cardinit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        initStart,
  input  logic        checkOcr,
  input  logic        dummyDone,
  input  logic        cmdDone,
  input  logic        r1Err,
  input  logic        r1Idle,
  input  logic        r1ExactIdle,
  input  logic        voltOk,
  input  logic        pollLast,
  output dpCtl_t      ctl,
  output logic        dummyReq,
  output logic        csHigh,
  output logic        cmdStart,
  output logic [5:0]  cmdIdx,
  output logic [7:0]  cmdCrc,
  output logic        cmdLongRsp,
  output logic        seqDone
);
  typedef enum logic [3:0] {
    S_IDLE, S_DREQ, S_DWAIT, S_SEND0, S_WAIT0,
    S_SEND58, S_WAIT58, S_SEND1, S_WAIT1, S_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState  = state;
    ctl        = '0;
    ctl.code   = ST_NONE;
    dummyReq   = 1'b0;
    csHigh     = 1'b0;
    cmdStart   = 1'b0;
    cmdIdx     = IDX_RESET;
    cmdCrc     = CRC_RESET;
    cmdLongRsp = 1'b0;
    seqDone    = 1'b0;
    unique case (state)
      S_IDLE, S_DONE: begin
        seqDone = (state == S_DONE);
        if (initStart) begin
          ctl.clrAll = 1'b1;
          nextState  = S_DREQ;
        end
      end
      S_DREQ: begin
        dummyReq  = 1'b1;
        csHigh    = 1'b1;
        nextState = S_DWAIT;
      end
      S_DWAIT: begin
        csHigh = 1'b1;
        if (dummyDone) nextState = S_SEND0;
      end
      S_SEND0: begin
        cmdStart  = 1'b1;
        nextState = S_WAIT0;
      end
      S_WAIT0: if (cmdDone) begin
        if (r1Err) begin
          ctl.setStatus = 1'b1; ctl.code = ST_R1ERR; nextState = S_DONE;
        end else if (!r1ExactIdle) begin
          ctl.setStatus = 1'b1; ctl.code = ST_BADRST; nextState = S_DONE;
        end else begin
          nextState = checkOcr ? S_SEND58 : S_SEND1;
        end
      end
      S_SEND58: begin
        cmdStart   = 1'b1;
        cmdIdx     = IDX_RDOCR;
        cmdCrc     = CRC_RDOCR;
        cmdLongRsp = 1'b1;
        nextState  = S_WAIT58;
      end
      S_WAIT58: if (cmdDone) begin
        if (r1Err) begin
          ctl.setStatus = 1'b1; ctl.code = ST_R1ERR; nextState = S_DONE;
        end else if (!voltOk) begin
          ctl.setStatus = 1'b1; ctl.code = ST_VFAIL; nextState = S_DONE;
        end else begin
          nextState = S_SEND1;
        end
      end
      S_SEND1: begin
        cmdStart  = 1'b1;
        cmdIdx    = IDX_OPCND;
        cmdCrc    = CRC_OPCND;
        nextState = S_WAIT1;
      end
      S_WAIT1: if (cmdDone) begin
        if (r1Err) begin
          ctl.setStatus = 1'b1; ctl.code = ST_R1ERR; nextState = S_DONE;
        end else if (!r1Idle) begin
          ctl.setStatus = 1'b1; ctl.code = ST_READY; nextState = S_DONE;
        end else if (pollLast) begin
          ctl.setStatus = 1'b1; ctl.code = ST_TMO; nextState = S_DONE;
        end else begin
          ctl.incPoll = 1'b1; nextState = S_SEND1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/spi_card_init.sv
module spi_card_init
  import cardinit_pkg::*;
#(
  parameter int MAX_POLLS = 16,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          initStart,
  input  logic          checkOcr,
  input  logic [VW-1:0] hostVolt,
  output logic          dummyReq,
  output logic          csHigh,
  input  logic          dummyDone,
  output logic          cmdStart,
  output logic [5:0]    cmdIdx,
  output logic [31:0]   cmdArg,
  output logic [7:0]    cmdCrc,
  output logic          cmdLongRsp,
  input  logic          cmdDone,
  input  logic [7:0]    rspR1,
  input  logic [31:0]   rspOcr,
  output logic          seqDone,
  output logic [2:0]    seqStatus,
  output logic          ready
);
  dpCtl_t     ctl;
  seqStatus_e status;
  logic r1Err, r1Idle, r1ExactIdle, voltOk, pollLast;

  cardinit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .initStart(initStart), .checkOcr(checkOcr),
    .dummyDone(dummyDone), .cmdDone(cmdDone), .r1Err(r1Err), .r1Idle(r1Idle),
    .r1ExactIdle(r1ExactIdle), .voltOk(voltOk), .pollLast(pollLast), .ctl(ctl),
    .dummyReq(dummyReq), .csHigh(csHigh), .cmdStart(cmdStart), .cmdIdx(cmdIdx),
    .cmdCrc(cmdCrc), .cmdLongRsp(cmdLongRsp), .seqDone(seqDone)
  );

  cardinit_dp #(.MAX_POLLS(MAX_POLLS), .VW(VW), .VLO(24 - VW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rspR1(rspR1), .rspOcr(rspOcr),
    .hostVolt(hostVolt), .r1Err(r1Err), .r1Idle(r1Idle), .r1ExactIdle(r1ExactIdle),
    .voltOk(voltOk), .pollLast(pollLast), .status(status)
  );

  assign cmdArg    = '0;
  assign seqStatus = status;
  assign ready     = seqDone && (status == ST_READY);
endmodule

// File: rtl/spi_card_init_chk.sv
module spi_card_init_chk (
  input logic       clk,
  input logic       rstN,
  input logic       initStart,
  input logic       dummyReq,
  input logic       csHigh,
  input logic       cmdStart,
  input logic [5:0] cmdIdx,
  input logic [7:0] cmdCrc,
  input logic       cmdLongRsp,
  input logic       seqDone,
  input logic [2:0] seqStatus
);
  AST_CS_IN_DUMMY: assert property (@(posedge clk) disable iff (!rstN)
    dummyReq |-> csHigh); // R1
  AST_RESET_CRC: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && cmdIdx == 6'd0) |-> (cmdCrc == 8'h95)); // R2
  AST_LONG_FOR_OCR: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> (cmdLongRsp == (cmdIdx == 6'd58))); // R4
  AST_LEGAL_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> (cmdIdx == 6'd0 || cmdIdx == 6'd1 || cmdIdx == 6'd58)); // R10
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && !initStart) |=> (seqDone && $stable(seqStatus))); // R11
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (!cmdStart && !csHigh && seqStatus != 3'd0)); // R11
endmodule

bind spi_card_init spi_card_init_chk u_chk (
  .clk(clk), .rstN(rstN), .initStart(initStart), .dummyReq(dummyReq),
  .csHigh(csHigh), .cmdStart(cmdStart), .cmdIdx(cmdIdx), .cmdCrc(cmdCrc),
  .cmdLongRsp(cmdLongRsp), .seqDone(seqDone), .seqStatus(seqStatus)
);

// File: tb/test_spi_card_init.sv
module test_spi_card_init;
  localparam int MAXP = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, initStart = 1'b0, checkOcr = 1'b0, dummyDone = 1'b0, cmdDone = 1'b0;
  logic [8:0] hostVolt = 9'h1FF;
  logic [7:0] rspR1 = 8'h00;
  logic [31:0] rspOcr = 32'h0;
  logic dummyReq, csHigh, cmdStart, cmdLongRsp, seqDone, ready;
  logic [5:0] cmdIdx;
  logic [31:0] cmdArg;
  logic [7:0] cmdCrc;
  logic [2:0] seqStatus;

  spi_card_init #(.MAX_POLLS(MAXP)) i_spi_card_init (
    .clk(clk), .rstN(rstN), .initStart(initStart), .checkOcr(checkOcr), .hostVolt(hostVolt),
    .dummyReq(dummyReq), .csHigh(csHigh), .dummyDone(dummyDone), .cmdStart(cmdStart),
    .cmdIdx(cmdIdx), .cmdArg(cmdArg), .cmdCrc(cmdCrc), .cmdLongRsp(cmdLongRsp),
    .cmdDone(cmdDone), .rspR1(rspR1), .rspOcr(rspOcr), .seqDone(seqDone),
    .seqStatus(seqStatus), .ready(ready)
  );

  int nChecks = 0, nFails = 0, cycles = 0;

  // card model configuration
  logic [7:0] r0Rsp, r58Rsp, finalRsp;
  logic [31:0] r58Ocr;
  int idleResp;

  // model state and logs
  int cmdDelay = -1, dumDelay = -1, cmd1Seen = 0;
  logic [5:0] pendIdx;
  bit inDummy = 0, busyCmd = 0;
  int nCmd0, nCmd1, nCmd58, nTotal;
  int firstIdx, secondIdx;
  bit badCrc0, badArg, badLong, csViol, overlap, cmdInDummy, sawDummy;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    nCmd0 = 0; nCmd1 = 0; nCmd58 = 0; nTotal = 0; cmd1Seen = 0;
    firstIdx = -1; secondIdx = -1;
    badCrc0 = 0; badArg = 0; badLong = 0; csViol = 0; overlap = 0;
    cmdInDummy = 0; sawDummy = 0;
  endtask

  task automatic setCard(input logic [7:0] a, input logic [7:0] b, input logic [31:0] o,
                         input int idles, input logic [7:0] fin, input bit useOcr);
    r0Rsp = a; r58Rsp = b; r58Ocr = o; idleResp = idles; finalRsp = fin; checkOcr = useOcr;
  endtask

  always @(negedge clk) begin
    cycles++;
    dummyDone = 1'b0;
    cmdDone   = 1'b0;
    if (inDummy && !csHigh) csViol = 1;
    if (dumDelay > 0) dumDelay--;
    else if (dumDelay == 0) begin
      dummyDone = 1'b1; dumDelay = -1; inDummy = 0;
    end
    if (cmdDelay > 0) cmdDelay--;
    else if (cmdDelay == 0) begin
      cmdDone = 1'b1; cmdDelay = -1; busyCmd = 0; rspOcr = 32'h0;
      if (pendIdx == 6'd0) rspR1 = r0Rsp;
      else if (pendIdx == 6'd58) begin rspR1 = r58Rsp; rspOcr = r58Ocr; end
      else begin
        rspR1 = (cmd1Seen < idleResp) ? 8'h01 : finalRsp;
        cmd1Seen++;
      end
    end
    if (dummyReq) begin inDummy = 1; sawDummy = 1; dumDelay = 5; end
    if (cmdStart) begin
      if (inDummy) cmdInDummy = 1;
      if (busyCmd) overlap = 1;
      if (nTotal == 0) firstIdx = int'(cmdIdx);
      if (nTotal == 1) secondIdx = int'(cmdIdx);
      nTotal++;
      if (cmdIdx == 6'd0) begin nCmd0++; if (cmdCrc != 8'h95) badCrc0 = 1; end
      else if (cmdIdx == 6'd1) nCmd1++;
      else if (cmdIdx == 6'd58) nCmd58++;
      if (cmdArg != 32'h0) badArg = 1;
      if (cmdLongRsp != (cmdIdx == 6'd58)) badLong = 1;
      busyCmd = 1; pendIdx = cmdIdx; cmdDelay = 3;
    end
  end

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
    finish();
  end

  task automatic runSeq(input int midPulse);
    int n;
    clearLog();
    @(negedge clk); initStart = 1'b1;
    @(negedge clk); initStart = 1'b0;
    n = 0;
    while (!seqDone && n < 5000) begin
      @(negedge clk); n++;
      if (n == midPulse) initStart = 1'b1;
      else initStart = 1'b0;
    end
    initStart = 1'b0;
    chk(seqDone, "R11", "sequence finished", int'(seqDone), 1);
    chk(sawDummy && !csViol && !cmdInDummy, "R1", "idle clocks with CS high first",
        int'(csViol) + 2 * int'(cmdInDummy), 0);
    chk(firstIdx == 0 && !badCrc0 && !badArg, "R2", "reset command first with 0x95", firstIdx, 0);
    chk(!overlap && !badLong && nTotal == nCmd0 + nCmd1 + nCmd58, "R10", "legal single commands",
        nTotal, nCmd0 + nCmd1 + nCmd58);
  endtask

  task automatic expectEnd(input int st, input int c1, input int c58, input string req);
    int hold;
    chk(int'(seqStatus) == st, req, "status", int'(seqStatus), st);
    chk(nCmd1 == c1, req, "CMD1 count", nCmd1, c1);
    chk(nCmd58 == c58, req, "CMD58 count", nCmd58, c58);
    chk(ready == (st == 1), "R7", "ready flag", int'(ready), int'(st == 1));
    hold = nTotal;
    repeat (12) @(negedge clk);
    chk(seqDone && int'(seqStatus) == st && nTotal == hold, "R11", "result held",
        int'(seqStatus), st);
  endtask

  task automatic tReset();
    chk(!seqDone && !ready && !cmdStart && !dummyReq && !csHigh && seqStatus == 3'd0,
        "R12", "reset outputs", int'(seqStatus) + int'(seqDone) + int'(csHigh), 0);
  endtask

  task automatic tPlainReady();
    setCard(8'h01, 8'h00, 32'h0, 3, 8'h00, 0);
    runSeq(-1);
    chk(secondIdx == 1, "R5", "CMD1 right after reset", secondIdx, 1);
    chk(!badArg, "R6", "CMD1 argument zero", int'(badArg), 0);
    expectEnd(1, 4, 0, "R7");
  endtask

  task automatic tOcrOk();
    hostVolt = 9'h1FF;
    setCard(8'h01, 8'h01, 32'h00FF8000, 1, 8'h00, 1);
    runSeq(-1);
    chk(secondIdx == 58, "R4", "CMD58 after reset", secondIdx, 58);
    expectEnd(1, 2, 1, "R4");
  endtask

  task automatic tOcrFail();
    hostVolt = 9'h0FF;
    setCard(8'h01, 8'h01, 32'h00800000, 0, 8'h00, 1);
    runSeq(-1);
    expectEnd(2, 0, 1, "R4");
    hostVolt = 9'h1FF;
  endtask

  task automatic tTimeout();
    setCard(8'h01, 8'h00, 32'h0, 100000, 8'h00, 0);
    runSeq(-1);
    expectEnd(3, MAXP, 0, "R8");
  endtask

  task automatic tLastAttempt();
    setCard(8'h01, 8'h00, 32'h0, MAXP - 1, 8'h00, 0);
    runSeq(-1);
    expectEnd(1, MAXP, 0, "R8");
  endtask

  task automatic tBadReset();
    setCard(8'h00, 8'h00, 32'h0, 0, 8'h00, 0);
    runSeq(-1);
    expectEnd(5, 0, 0, "R3");
    setCard(8'h05, 8'h00, 32'h0, 0, 8'h00, 0);
    runSeq(-1);
    expectEnd(4, 0, 0, "R3");
  endtask

  task automatic tPollError();
    setCard(8'h01, 8'h00, 32'h0, 2, 8'h04, 0);
    runSeq(-1);
    expectEnd(4, 3, 0, "R9");
    setCard(8'h01, 8'h09, 32'h00FF8000, 0, 8'h00, 1);
    runSeq(-1);
    expectEnd(4, 0, 1, "R9");
  endtask

  task automatic tBusyIgnore();
    setCard(8'h01, 8'h00, 32'h0, 10, 8'h00, 0);
    runSeq(30);
    chk(nCmd0 == 1, "R11", "start while busy ignored", nCmd0, 1);
    expectEnd(1, 11, 0, "R6");
  endtask

  initial begin
    clearLog();
    setCard(8'h01, 8'h00, 32'h0, 0, 8'h00, 0);
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPlainReady();
    tOcrOk();
    tOcrFail();
    tTimeout();
    tLastAttempt();
    tBadReset();
    tPollError();
    tBusyIgnore();
    finish();
  end
endmodule